// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles the outcome of a branch instruction in the same cycle that it is decoded. It takes the branch's decoded fields together with the current program counter, the condition register and the loop count register. From these it produces four results: whether the branch is taken, the branch target, the next fetch address, and the new count register value with its write enable. All outputs are combinational, so the core can commit the counter and redirect fetch in the same cycle.

There are four branch forms. An immediate branch always jumps, to a scaled word offset that is either added to the PC or used on its own. A displacement branch is conditional and also scales its offset, relative or absolute. A register branch is conditional and takes its target from a register input. A fourth encoding marks "no branch".

A 5-bit option field controls the conditional forms. It can skip or enable a counter decrement with a zero or non-zero test. It can also ignore one condition-register bit, or test that bit against either polarity.

Top module: `brx_branch_resolve`

## Requirements
- R1: With `br_kind`=00 (immediate form), the offset is `imm_field` shifted left by 2 and sign-extended from its bit 25. With `abs_mode`=0 the target is `pc` plus that offset, wrapping modulo 2^32.
- R2: With `br_kind`=01 (displacement form), the offset is `disp_field` shifted left by 2 and sign-extended from its bit 15. With `abs_mode`=0 the target is `pc` plus that offset, wrapping.
- R3: With `abs_mode`=1, the immediate and displacement forms use the sign-extended offset itself as the target, and `pc` has no influence.
- R4: For conditional forms (`br_kind` 01 or 10) with `opt` bit 2 set, the counter test passes, `cnt_we`=0 and `cnt_out` equals `cnt_in`.
- R5: For conditional forms with `opt` bit 2 clear, `cnt_out` = `cnt_in`-1 (0 wraps to all ones) and `cnt_we`=1. The counter test passes when that new value is non-zero and `opt` bit 1 is 0, or when it is zero and `opt` bit 1 is 1.
- R6: With `opt` bit 4 set, the condition test passes whatever the condition register holds.
- R7: With `opt` bit 4 clear, the condition test passes only when `cond_reg[31-bit_sel]` equals `opt` bit 3. Bit number 0 is therefore the most significant bit.
- R8: A conditional branch is taken exactly when the counter test and the condition test both pass.
- R9: The immediate form is always taken, with `cnt_we`=0 and `cnt_out`=`cnt_in`.
- R10: `next_pc` equals `target` when taken and `pc`+4 otherwise.
- R11: With `br_kind`=10 (register form), `target` equals `reg_target` unchanged.
- R12: With `br_kind`=11 (no branch), `taken`=0, `cnt_we`=0, `cnt_out`=`cnt_in` and `next_pc`=`pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_kind | input | 2 | Form: 00 immediate, 01 displacement, 10 register, 11 none |
| abs_mode | input | 1 | 1 = offset is the target, 0 = offset is added to pc |
| opt | input | 5 | Option field controlling the counter and condition tests |
| bit_sel | input | 5 | Condition-register bit number, 0 = most significant |
| imm_field | input | 24 | Word offset of the immediate form |
| disp_field | input | 14 | Word offset of the displacement form |
| pc | input | 32 | Address of the branch |
| cond_reg | input | 32 | Condition register |
| cnt_in | input | 32 | Current count register |
| reg_target | input | 32 | Target for the register form |
| taken | output | 1 | Branch is taken |
| target | output | 32 | Branch target address |
| next_pc | output | 32 | Next fetch address |
| cnt_out | output | 32 | New count register value |
| cnt_we | output | 1 | Count register write enable |

## Verification
The bench uses the default widths: a 32-bit datapath, a 24-bit immediate and a 14-bit displacement. At these widths the sign bits sit at positions 25 and 15, so the largest positive and negative offsets can be driven directly. Every position 0..31 is reachable by `bit_sel`, which exercises the index reversal at both ends of the condition register. A full 32-bit counter makes the wrap from 0 to all ones, and the exact-1 case, reachable alongside a large count.

// File: rtl/brx_pkg.sv
package brx_pkg;
    typedef enum logic [1:0] {
        KIND_IMM  = 2'b00,
        KIND_DISP = 2'b01,
        KIND_REG  = 2'b10,
        KIND_NONE = 2'b11
    } brx_kind_e;

    // option field bit positions
    localparam int OPT_W         = 5;
    localparam int OPT_CNT_WANT0 = 1;
    localparam int OPT_CNT_SKIP  = 2;
    localparam int OPT_CND_WANT  = 3;
    localparam int OPT_CND_SKIP  = 4;
endpackage

// File: rtl/brx_offset_ext.sv
module brx_offset_ext #(
    parameter int FIELD_W = 24,
    parameter int XLEN    = 32
) (
    input  logic [FIELD_W-1:0] field,
    output logic [XLEN-1:0]    offset
);
    localparam int SH_W = FIELD_W + 2;
    logic [SH_W-1:0] scaled;

    assign scaled = {field, 2'b00};

    generate
        if (XLEN > SH_W) begin : g_extend
            assign offset = {{(XLEN-SH_W){scaled[SH_W-1]}}, scaled};
        end else begin : g_trunc
            assign offset = scaled[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/brx_count_test.sv
module brx_count_test #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cnt_in,
    input  logic            skip,
    input  logic            want_zero,
    output logic            pass,
    output logic [XLEN-1:0] cnt_next,
    output logic            dec_en
);
    logic [XLEN-1:0] dec_val;

    always_comb begin
        dec_val = cnt_in - XLEN'(1);
        if (skip) begin
            pass     = 1'b1;
            cnt_next = cnt_in;
            dec_en   = 1'b0;
        end else begin
            pass     = (dec_val == '0) == want_zero;
            cnt_next = dec_val;
            dec_en   = 1'b1;
        end
    end
endmodule

// File: rtl/brx_cond_test.sv
module brx_cond_test #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         cond_reg,
    input  logic [$clog2(XLEN)-1:0] bit_sel,
    input  logic                    ignore,
    input  logic                    want,
    output logic                    pass
);
    localparam int SEL_W = $clog2(XLEN);
    logic [SEL_W-1:0] pos;

    always_comb begin
        pos  = SEL_W'(XLEN - 1) - bit_sel;
        pass = ignore ? 1'b1 : (cond_reg[pos] == want);
    end
endmodule

// File: rtl/brx_branch_resolve.sv
module brx_branch_resolve #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 24,
    parameter int DISP_W = 14,
    parameter int SEL_W  = $clog2(XLEN)
) (
    input  logic [1:0]        br_kind,
    input  logic              abs_mode,
    input  logic [4:0]        opt,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DISP_W-1:0] disp_field,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   cond_reg,
    input  logic [XLEN-1:0]   cnt_in,
    input  logic [XLEN-1:0]   reg_target,
    output logic              taken,
    output logic [XLEN-1:0]   target,
    output logic [XLEN-1:0]   next_pc,
    output logic [XLEN-1:0]   cnt_out,
    output logic              cnt_we
);
    import brx_pkg::*;

    brx_kind_e       kind;
    logic [XLEN-1:0] imm_off, disp_off, sel_off, fall_pc;
    logic            cnt_pass, cnd_pass, dec_en;
    logic [XLEN-1:0] cnt_next;

    assign kind    = brx_kind_e'(br_kind);
    assign fall_pc = pc + XLEN'(4);

    brx_offset_ext #(.FIELD_W(IMM_W), .XLEN(XLEN)) u_imm_ext (
        .field(imm_field), .offset(imm_off)
    );

    brx_offset_ext #(.FIELD_W(DISP_W), .XLEN(XLEN)) u_disp_ext (
        .field(disp_field), .offset(disp_off)
    );

    brx_count_test #(.XLEN(XLEN)) u_cnt (
        .cnt_in   (cnt_in),
        .skip     (opt[OPT_CNT_SKIP]),
        .want_zero(opt[OPT_CNT_WANT0]),
        .pass     (cnt_pass),
        .cnt_next (cnt_next),
        .dec_en   (dec_en)
    );

    brx_cond_test #(.XLEN(XLEN)) u_cnd (
        .cond_reg(cond_reg),
        .bit_sel (bit_sel),
        .ignore  (opt[OPT_CND_SKIP]),
        .want    (opt[OPT_CND_WANT]),
        .pass    (cnd_pass)
    );

    always_comb begin
        sel_off = (kind == KIND_IMM) ? imm_off : disp_off;
        taken   = 1'b0;
        target  = fall_pc;
        cnt_out = cnt_in;
        cnt_we  = 1'b0;
        unique case (kind)
            KIND_IMM: begin
                taken  = 1'b1;
                target = abs_mode ? sel_off : pc + sel_off;
            end
            KIND_DISP: begin
                taken   = cnt_pass && cnd_pass;
                target  = abs_mode ? sel_off : pc + sel_off;
                cnt_out = cnt_next;
                cnt_we  = dec_en;
            end
            KIND_REG: begin
                taken   = cnt_pass && cnd_pass;
                target  = reg_target;
                cnt_out = cnt_next;
                cnt_we  = dec_en;
            end
            KIND_NONE: begin
                taken = 1'b0;
            end
        endcase
        next_pc = taken ? target : fall_pc;
    end
endmodule

// File: rtl/brx_branch_resolve_chk.sv
module brx_branch_resolve_chk (
    input logic [1:0]  br_kind,
    input logic [4:0]  opt,
    input logic [31:0] pc,
    input logic [31:0] cnt_in,
    input logic [31:0] reg_target,
    input logic        taken,
    input logic [31:0] target,
    input logic [31:0] next_pc,
    input logic [31:0] cnt_out,
    input logic        cnt_we
);
    logic is_cond;
    assign is_cond = (br_kind == 2'b01) || (br_kind == 2'b10);

    always_comb begin
        if (br_kind == 2'b00)
            assert_imm_taken_R9: assert (taken && !cnt_we && cnt_out == cnt_in);
        if (is_cond && opt[2])
            assert_cnt_hold_R4: assert (!cnt_we && cnt_out == cnt_in);
        if (is_cond && !opt[2])
            assert_cnt_dec_R5: assert (cnt_we && cnt_out == cnt_in - 32'd1);
        if (is_cond && opt[2] && opt[4])
            assert_both_skip_R8: assert (taken);
        if (br_kind == 2'b10)
            assert_reg_target_R11: assert (target == reg_target);
        if (br_kind == 2'b11)
            assert_no_branch_R12: assert (!taken && !cnt_we && next_pc == pc + 32'd4);
        if (!taken)
            assert_fall_through_R10: assert (next_pc == pc + 32'd4);
    end
endmodule

bind brx_branch_resolve brx_branch_resolve_chk chk_i (
    .br_kind   (br_kind),
    .opt       (opt),
    .pc        (pc),
    .cnt_in    (cnt_in),
    .reg_target(reg_target),
    .taken     (taken),
    .target    (target),
    .next_pc   (next_pc),
    .cnt_out   (cnt_out),
    .cnt_we    (cnt_we)
);

// File: tb/brx_branch_resolve_tb.sv
module brx_branch_resolve_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [1:0]  br_kind = 2'b11;
    logic        abs_mode = 1'b0;
    logic [4:0]  opt = '0;
    logic [4:0]  bit_sel = '0;
    logic [23:0] imm_field = '0;
    logic [13:0] disp_field = '0;
    logic [31:0] pc = '0, cond_reg = '0, cnt_in = '0, reg_target = '0;
    logic        taken, cnt_we;
    logic [31:0] target, next_pc, cnt_out;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brx_branch_resolve dut_i (
        .br_kind(br_kind), .abs_mode(abs_mode), .opt(opt), .bit_sel(bit_sel),
        .imm_field(imm_field), .disp_field(disp_field), .pc(pc),
        .cond_reg(cond_reg), .cnt_in(cnt_in), .reg_target(reg_target),
        .taken(taken), .target(target), .next_pc(next_pc),
        .cnt_out(cnt_out), .cnt_we(cnt_we)
    );

    function automatic logic [31:0] f_target();
        logic [31:0] off;
        if (br_kind == 2'b00) off = {{6{imm_field[23]}}, imm_field, 2'b00};   // R1
        else                  off = {{16{disp_field[13]}}, disp_field, 2'b00}; // R2
        if (br_kind == 2'b10) return reg_target;                               // R11
        if (br_kind == 2'b11) return 32'hx;
        return abs_mode ? off : pc + off;                                      // R3
    endfunction

    function automatic logic f_taken();
        logic [31:0] nc;
        logic cp, dp;
        if (br_kind == 2'b00) return 1'b1;   // R9
        if (br_kind == 2'b11) return 1'b0;   // R12
        nc = cnt_in - 32'd1;
        cp = opt[2] ? 1'b1 : ((nc != 0 && !opt[1]) || (nc == 0 && opt[1]));  // R4 R5
        dp = opt[4] ? 1'b1 : (cond_reg[31 - bit_sel] == opt[3]);              // R6 R7
        return cp && dp;                                                       // R8
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h (kind %b opt %b)", req, act, exp, br_kind, opt);
        end
    endtask

    task automatic apply();
        logic        e_tk, e_we;
        logic [31:0] e_tg, e_cnt;
        #1;
        vectors++;
        e_tk  = f_taken();
        e_tg  = f_target();
        e_we  = (br_kind == 2'b01 || br_kind == 2'b10) && !opt[2];
        e_cnt = e_we ? cnt_in - 32'd1 : cnt_in;
        check32(br_kind == 2'b00 ? "R9" : (opt[4] ? "R6" : "R7/R8"), {31'd0, taken}, {31'd0, e_tk});
        if (br_kind != 2'b11)
            check32(br_kind == 2'b00 ? "R1/R3" : (br_kind == 2'b01 ? "R2/R3" : "R11"), target, e_tg);
        check32("R10", next_pc, e_tk ? e_tg : pc + 32'd4);
        check32(opt[2] ? "R4" : "R5", cnt_out, e_cnt);
        check32(br_kind == 2'b11 ? "R12" : "R4/R5", {31'd0, cnt_we}, {31'd0, e_we});
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] cnts[3];
        cnts[0] = 32'd1; cnts[1] = 32'd0; cnts[2] = 32'h8000_1234;
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        // no-branch state, R12
        pc = 32'h0000_1000; cnt_in = 32'd7;
        apply();
        // every option value, counts 1/0/large, both polarities, both cond kinds
        for (int k = 1; k <= 2; k++)
            for (int o = 0; o < 32; o++)
                for (int c = 0; c < 3; c++)
                    for (int p = 0; p < 2; p++) begin
                        br_kind = 2'(k); opt = 5'(o); cnt_in = cnts[c];
                        bit_sel = 5'(o * 7 + c);
                        cond_reg = p ? (32'h1 << (31 - bit_sel)) : ~(32'h1 << (31 - bit_sel));
                        disp_field = 14'(o * 131 + c); reg_target = 32'hCAFE_0000 + 32'(o);
                        abs_mode = p[0];
                        apply();
                    end
        // bit-number ends, R7
        br_kind = 2'b01; opt = 5'b00100;
        cond_reg = 32'h8000_0000; bit_sel = 5'd0;  apply();
        cond_reg = 32'h0000_0001; bit_sel = 5'd31; apply();
        opt = 5'b01100; apply();
        // offset extremes, R1 R2 R3
        pc = 32'hFFFF_FFF0;
        br_kind = 2'b00;
        for (int a = 0; a < 2; a++) begin
            abs_mode = a[0];
            imm_field = 24'h7F_FFFF; apply();
            imm_field = 24'h80_0000; apply();
        end
        br_kind = 2'b01; opt = 5'b10100;
        for (int a = 0; a < 2; a++) begin
            abs_mode = a[0];
            disp_field = 14'h1FFF; apply();
            disp_field = 14'h2000; apply();
        end
        // no-branch with tempting options, R12
        br_kind = 2'b11; opt = 5'b10100; apply();
        // random mix
        for (int i = 0; i < 3000; i++) begin
            br_kind = 2'($urandom); abs_mode = 1'($urandom); opt = 5'($urandom);
            bit_sel = 5'($urandom); imm_field = 24'($urandom); disp_field = 14'($urandom);
            pc = $urandom & 32'hFFFF_FFFC; cond_reg = $urandom;
            cnt_in = ($urandom % 4 == 0) ? 32'($urandom % 3) : $urandom;
            reg_target = $urandom;
            apply();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule